// File: doc/BRIEF.md
# Pane-Based Sliding-Window Aggregator

This block computes COUNT, SUM, MIN or MAX over overlapping time-based sliding windows on one stream of tuples. It does not keep one accumulator per open window. Time is cut into non-overlapping panes of a configured length, starting at time zero. A pane stage folds each accepted tuple into a single running partial. When a tuple's timestamp reaches the end of the current pane, the pane closes and its partial is pushed into a pane buffer. A window stage then folds the newest buffered partials into one window result.

The configuration sets four things: the pane length (the greatest common divisor of range and slide), the number of panes per window, the number of panes per slide, and the function. A fifth setting, the attribute select, picks which fixed-width field of the tuple is aggregated. The configuration must be held steady between resets. Averages are formed outside the block from a SUM run and a COUNT run.

A tuple may jump past several pane ends at once. In that case the block closes one pane per cycle and holds the tuple until its own pane is open. Panes that received no tuple emit the identity value of the function.

Top module: `pane_window_agg`

## Requirements
- R1: Pane p covers timestamps [p*L, (p+1)*L), where L is `cfg_pane_len` and pane 0 starts at time 0. A pane closes only when a tuple is presented whose timestamp is at or beyond the end of that pane.
- R2: Each cycle in which a presented tuple lies beyond the current pane end closes exactly one pane, and `in_ready` is low in that cycle. The tuple is accepted in the first cycle in which it lies inside the open pane.
- R3: A closed pane's value is the fold of the accepted tuples in that pane. The function codes on `cfg_fn` are 0 = COUNT, 1 = SUM, 2 = MIN and 3 = MAX. Attribute values are unsigned and zero-extended to 64 bits.
- R4: A pane that received no tuple emits the identity of the function: 0 for COUNT, SUM and MAX, and all ones for MIN.
- R5: `pane_valid` pulses for one cycle per closed pane, in the clock cycle after the cycle in which the pane closed.
- R6: A window result is emitted at the k-th pane close when k is a multiple of `cfg_slide_panes` and k >= `cfg_win_panes`. Its value folds the newest `cfg_win_panes` pane values: counts and sums are added, MIN takes the minimum and MAX takes the maximum.
- R7: `win_valid` pulses in the clock cycle after the `pane_valid` pulse that triggered it.
- R8: `cfg_attr` = a selects tuple bits [a*ATTR_W +: ATTR_W] as the aggregated attribute.
- R9: After reset, with no tuple presented, `in_ready` is high and `pane_valid` and `win_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fn | input | 2 | Aggregate function code |
| cfg_attr | input | SEL_W | Attribute index within the tuple |
| cfg_pane_len | input | TS_W | Pane length in timestamp units |
| cfg_win_panes | input | NP_W | Panes per window (1..NP_MAX) |
| cfg_slide_panes | input | NP_W | Panes per slide (1..NP_MAX) |
| in_valid | input | 1 | Tuple presented |
| in_ts | input | TS_W | Tuple timestamp, non-decreasing |
| in_data | input | NATTR*ATTR_W | Packed tuple attributes |
| in_ready | output | 1 | Tuple accepted this cycle when high with in_valid |
| pane_valid | output | 1 | Pane partial valid |
| pane_value | output | 64 | Pane partial |
| win_valid | output | 1 | Window result valid |
| win_value | output | 64 | Window result |

## Verification
The hardest situation to reach from the ports is a run of back-to-back pane closes that includes empty panes, followed by a window that spans those identity values. Reaching it needs a timestamp that jumps more than one pane ahead while the tuple is held. The stimulus table contains two such jumps, and it is replayed under all four functions with different window and slide counts. This puts empty panes at the start, middle and end of windows, and it checks both the number of stall cycles and the pane that follows each stall.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

    localparam int ACC_W = 64;

    typedef enum logic [1:0] {
        FN_COUNT = 2'd0,
        FN_SUM   = 2'd1,
        FN_MIN   = 2'd2,
        FN_MAX   = 2'd3
    } agg_fn_e;

    function automatic logic [ACC_W-1:0] agg_ident(agg_fn_e f);
        return (f == FN_MIN) ? '1 : '0;
    endfunction

    function automatic logic [ACC_W-1:0] agg_fold(agg_fn_e f,
                                                  logic [ACC_W-1:0] a,
                                                  logic [ACC_W-1:0] b);
        case (f)
            FN_COUNT, FN_SUM: return a + b;
            FN_MIN:           return (b < a) ? b : a;
            default:          return (b > a) ? b : a;
        endcase
    endfunction

endpackage

// File: rtl/pwa_pane_clock.sv
module pwa_pane_clock #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [TS_W-1:0] in_ts,
    input  logic [TS_W-1:0] cfg_len,
    output logic            take,
    output logic            close,
    output logic            ready
);
    typedef struct packed {
        logic [TS_W-1:0] start;
    } clk_state_t;

    clk_state_t s_q, s_d;
    logic [TS_W-1:0] pane_end;

    always_comb begin
        s_d      = s_q;
        pane_end = s_q.start + cfg_len;
        close    = in_valid && (in_ts >= pane_end);
        take     = in_valid && !close;
        ready    = !close;
        if (close) begin
            s_d.start = pane_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pwa_pane_fold.sv
module pwa_pane_fold
    import pwa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  agg_fn_e          fn,
    input  logic             take,
    input  logic             close,
    input  logic [ACC_W-1:0] sample,
    output logic             pane_valid,
    output logic [ACC_W-1:0] pane_value
);
    typedef struct packed {
        logic             empty;
        logic [ACC_W-1:0] acc;
        logic             out_valid;
        logic [ACC_W-1:0] out_val;
    } fold_state_t;

    fold_state_t s_q, s_d;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] operand;

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        base          = s_q.empty ? agg_ident(fn) : s_q.acc;
        operand       = (fn == FN_COUNT) ? ACC_W'(1) : sample;
        if (take) begin
            s_d.acc   = agg_fold(fn, base, operand);
            s_d.empty = 1'b0;
        end
        if (close) begin
            s_d.out_valid = 1'b1;
            s_d.out_val   = base;
            s_d.empty     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{empty: 1'b1, acc: '0, out_valid: 1'b0, out_val: '0};
        else        s_q <= s_d;
    end

    assign pane_valid = s_q.out_valid;
    assign pane_value = s_q.out_val;

endmodule

// File: rtl/pwa_window.sv
module pwa_window
    import pwa_pkg::*;
#(
    parameter int NP_MAX = 16,
    parameter int NP_W   = $clog2(NP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  agg_fn_e          fn,
    input  logic [NP_W-1:0]  cfg_win,
    input  logic [NP_W-1:0]  cfg_slide,
    input  logic             pane_valid,
    input  logic [ACC_W-1:0] pane_value,
    output logic             win_valid,
    output logic [ACC_W-1:0] win_value
);
    typedef struct packed {
        logic [NP_MAX-1:0][ACC_W-1:0] panes;
        logic [NP_W-1:0]              fill;
        logic [NP_W-1:0]              slide_cnt;
        logic                         out_valid;
        logic [ACC_W-1:0]             out_val;
    } win_state_t;

    win_state_t s_q, s_d;
    logic [NP_W-1:0]  slide_next;
    logic             slide_hit;
    logic [ACC_W-1:0] fold_val;

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        slide_next    = s_q.slide_cnt + 1'b1;
        slide_hit     = (slide_next == cfg_slide);
        fold_val      = agg_ident(fn);
        if (pane_valid) begin
            s_d.panes[0] = pane_value;
            for (int i = 1; i < NP_MAX; i++) begin
                s_d.panes[i] = s_q.panes[i-1];
            end
            if (s_q.fill != NP_W'(NP_MAX)) s_d.fill = s_q.fill + 1'b1;
            s_d.slide_cnt = slide_hit ? '0 : slide_next;
            for (int i = 0; i < NP_MAX; i++) begin
                if (NP_W'(i) < cfg_win) fold_val = agg_fold(fn, fold_val, s_d.panes[i]);
            end
            if (slide_hit && (s_d.fill >= cfg_win)) begin
                s_d.out_valid = 1'b1;
                s_d.out_val   = fold_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign win_valid = s_q.out_valid;
    assign win_value = s_q.out_val;

    AST_WIN_FOLLOWS_PANE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> $past(pane_valid)); // R7

    AST_WIN_COVERS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && fn != FN_MIN) |-> (win_value >= $past(pane_value))); // R6

    AST_WIN_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && fn == FN_MIN) |-> (win_value <= $past(pane_value))); // R6

endmodule

// File: rtl/pane_window_agg.sv
module pane_window_agg
    import pwa_pkg::*;
#(
    parameter int NATTR  = 2,
    parameter int ATTR_W = 16,
    parameter int TS_W   = 32,
    parameter int NP_MAX = 16,
    localparam int DATA_W = NATTR * ATTR_W,
    localparam int SEL_W  = (NATTR > 1) ? $clog2(NATTR) : 1,
    localparam int NP_W   = $clog2(NP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fn,
    input  logic [SEL_W-1:0]  cfg_attr,
    input  logic [TS_W-1:0]   cfg_pane_len,
    input  logic [NP_W-1:0]   cfg_win_panes,
    input  logic [NP_W-1:0]   cfg_slide_panes,
    input  logic              in_valid,
    input  logic [TS_W-1:0]   in_ts,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              pane_valid,
    output logic [63:0]       pane_value,
    output logic              win_valid,
    output logic [63:0]       win_value
);
    agg_fn_e          fn;
    logic             take, close;
    logic [ACC_W-1:0] sample;

    assign fn     = agg_fn_e'(cfg_fn);
    assign sample = ACC_W'(in_data[cfg_attr*ATTR_W +: ATTR_W]);

    pwa_pane_clock #(.TS_W(TS_W)) u_clock (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_ts   (in_ts),
        .cfg_len (cfg_pane_len),
        .take    (take),
        .close   (close),
        .ready   (in_ready)
    );

    pwa_pane_fold u_fold (
        .clk       (clk),
        .rst_n     (rst_n),
        .fn        (fn),
        .take      (take),
        .close     (close),
        .sample    (sample),
        .pane_valid(pane_valid),
        .pane_value(pane_value)
    );

    pwa_window #(.NP_MAX(NP_MAX), .NP_W(NP_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .fn        (fn),
        .cfg_win   (cfg_win_panes),
        .cfg_slide (cfg_slide_panes),
        .pane_valid(pane_valid),
        .pane_value(pane_value),
        .win_valid (win_valid),
        .win_value (win_value)
    );

    AST_STALL_EMITS_PANE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> pane_valid); // R5

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> in_ready); // R2

endmodule

// File: tb/tb_pane_window_agg.sv
module tb_pane_window_agg;
    localparam int NATTR  = 2;
    localparam int ATTR_W = 16;
    localparam int TS_W   = 32;
    localparam int NP_MAX = 16;
    localparam int NP_W   = $clog2(NP_MAX + 1);
    localparam int PLEN   = 10;
    localparam int NVEC   = 12;

    // each entry: {timestamp, attribute 1, attribute 0}
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd1,  16'd100, 16'd5},
        {16'd4,  16'd7,   16'd9},
        {16'd8,  16'd30,  16'd2},
        {16'd12, 16'd1,   16'd7},
        {16'd15, 16'd2,   16'd3},
        {16'd27, 16'd4,   16'd11},
        {16'd29, 16'd9,   16'd1},
        {16'd45, 16'd6,   16'd6},
        {16'd52, 16'd8,   16'd4},
        {16'd53, 16'd3,   16'd8},
        {16'd71, 16'd2,   16'd2},
        {16'd80, 16'd0,   16'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_fn = '0;
    logic              cfg_attr = 1'b0;
    logic [TS_W-1:0]   cfg_pane_len = TS_W'(PLEN);
    logic [NP_W-1:0]   cfg_win_panes = NP_W'(1);
    logic [NP_W-1:0]   cfg_slide_panes = NP_W'(1);
    logic              in_valid = 1'b0;
    logic [TS_W-1:0]   in_ts = '0;
    logic [31:0]       in_data = '0;
    logic              in_ready, pane_valid, win_valid;
    logic [63:0]       pane_value, win_value;

    pane_window_agg #(.NATTR(NATTR), .ATTR_W(ATTR_W), .TS_W(TS_W), .NP_MAX(NP_MAX)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_fn(cfg_fn), .cfg_attr(cfg_attr),
        .cfg_pane_len(cfg_pane_len), .cfg_win_panes(cfg_win_panes),
        .cfg_slide_panes(cfg_slide_panes), .in_valid(in_valid), .in_ts(in_ts),
        .in_data(in_data), .in_ready(in_ready), .pane_valid(pane_valid),
        .pane_value(pane_value), .win_valid(win_valid), .win_value(win_value)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int stalls = 0;
    int np_got = 0;
    int nw_got = 0;
    int late_win = 0;
    logic prev_pane = 1'b0;
    logic [63:0] got_pane [32];
    logic [63:0] got_win  [32];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pane_valid && np_got < 32) got_pane[np_got] = pane_value;
            if (pane_valid) np_got++;
            if (win_valid && nw_got < 32) got_win[nw_got] = win_value;
            if (win_valid) nw_got++;
            if (win_valid && !prev_pane) late_win++;
            prev_pane = pane_valid;
        end
    end

    function automatic logic [63:0] ref_ident(input int f);
        return (f == 2) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
    endfunction

    function automatic logic [63:0] ref_fold(input int f, input logic [63:0] a, input logic [63:0] b);
        if (f <= 1) return a + b;
        if (f == 2) return (a < b) ? a : b;
        return (a > b) ? a : b;
    endfunction

    task automatic send(input logic [15:0] ts, input logic [31:0] d);
        bit rdy;
        bit done;
        in_valid = 1'b1;
        in_ts    = TS_W'(ts);
        in_data  = d;
        done = 1'b0;
        while (!done) begin
            #1;
            rdy = in_ready;
            @(negedge clk);
            if (rdy) done = 1'b1;
            else begin
                stalls++;
                check(pane_valid == 1'b1, "R5 pane after close", 64'(pane_valid), 64'd1);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic run(input int f, input bit attr, input int win, input int slide);
        logic [63:0] exp_pane [16];
        logic [63:0] exp_win  [16];
        bit          empty    [16];
        int closes;
        int nwin;
        cfg_fn          = 2'(f);
        cfg_attr        = attr;
        cfg_win_panes   = NP_W'(win);
        cfg_slide_panes = NP_W'(slide);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(in_ready == 1'b1, "R9 ready", 64'(in_ready), 64'd1);
        check(pane_valid == 1'b0, "R9 pane_valid", 64'(pane_valid), 64'd0);
        check(win_valid == 1'b0, "R9 win_valid", 64'(win_valid), 64'd0);
        rst_n = 1'b1;
        stalls = 0; np_got = 0; nw_got = 0; late_win = 0; prev_pane = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) send(VEC[i][47:32], VEC[i][31:0]);
        repeat (4) @(negedge clk);

        // reference model from the requirements
        closes = int'(VEC[NVEC-1][47:32]) / PLEN;
        for (int p = 0; p < 16; p++) begin
            exp_pane[p] = ref_ident(f);
            empty[p] = 1'b1;
            for (int i = 0; i < NVEC - 1; i++) begin
                if (int'(VEC[i][47:32]) / PLEN == p) begin
                    exp_pane[p] = ref_fold(f, exp_pane[p],
                        (f == 0) ? 64'd1 : 64'(attr ? VEC[i][31:16] : VEC[i][15:0]));
                    empty[p] = 1'b0;
                end
            end
        end
        nwin = 0;
        for (int k = 1; k <= closes; k++) begin
            if (k % slide == 0 && k >= win) begin
                exp_win[nwin] = ref_ident(f);
                for (int j = k - win; j < k; j++) exp_win[nwin] = ref_fold(f, exp_win[nwin], exp_pane[j]);
                nwin++;
            end
        end

        check(np_got == closes, "R1 pane count", 64'(np_got), 64'(closes));
        check(stalls == closes, "R2 stall cycles", 64'(stalls), 64'(closes));
        for (int p = 0; p < closes && p < np_got; p++) begin
            if (empty[p]) check(got_pane[p] == exp_pane[p], "R4 empty pane", got_pane[p], exp_pane[p]);
            else          check(got_pane[p] == exp_pane[p], "R3 R8 pane value", got_pane[p], exp_pane[p]);
        end
        check(nw_got == nwin, "R6 window count", 64'(nw_got), 64'(nwin));
        for (int w = 0; w < nwin && w < nw_got; w++)
            check(got_win[w] == exp_win[w], "R6 window value", got_win[w], exp_win[w]);
        check(late_win == 0, "R7 window timing", 64'(late_win), 64'd0);
    endtask

    // (fn, attr, win, slide) per run
    localparam int RUNS [4][4] = '{
        '{0, 0, 3, 1},
        '{1, 1, 4, 2},
        '{2, 0, 2, 1},
        '{3, 1, 3, 3}
    };

    initial begin
        for (int r = 0; r < 4; r++) run(RUNS[r][0], RUNS[r][1] != 0, RUNS[r][2], RUNS[r][3]);
        // corner: jump over three panes from reset with MIN, identity windows
        cfg_fn = 2'd2; cfg_attr = 1'b0; cfg_win_panes = NP_W'(2); cfg_slide_panes = NP_W'(1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        stalls = 0; np_got = 0; nw_got = 0; late_win = 0; prev_pane = 1'b0;
        @(negedge clk);
        send(16'd35, 32'h0000_0004);
        repeat (3) @(negedge clk);
        check(stalls == 3, "R2 multi-pane jump stalls", 64'(stalls), 64'd3);
        check(np_got == 3, "R1 panes before jump", 64'(np_got), 64'd3);
        check(got_pane[2] == 64'hFFFF_FFFF_FFFF_FFFF, "R4 MIN identity", got_pane[2], 64'hFFFF_FFFF_FFFF_FFFF);
        check(nw_got == 2, "R6 identity windows", 64'(nw_got), 64'd2);
        check(got_win[1] == 64'hFFFF_FFFF_FFFF_FFFF, "R6 MIN of empties", got_win[1], 64'hFFFF_FFFF_FFFF_FFFF);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule